// File: doc/BRIEF.md
# Channel-Budgeted Conversion Context Allocator

This block hands out one of three conversion contexts (A, B and C) to clients that ask for some number of audio channels. All three contexts draw on one shared pool of channels. A client pulses a request with a channel count. One clock later the block answers with a grant, the context it chose, or an error code that says why it refused. A client hands a context back with a release pulse and the context index. The channels held by that context go back into the pool, its sticky fault flags are wiped, and a per-context disable strobe tells the datapath to stop that context.

Contexts are not handed out in plain index order. A is preferred, then C, and B is used only when both A and C are taken. This keeps B, whose channel slots sit next to A's, as the last choice. A release and a request in the same cycle are resolved release-first, so a context or channels freed in that cycle can serve the request. Fault reports from the datapath set a sticky flag per context while that context is held.

Top module: `chan_ctx_allocator`

## Requirements
- R1: After reset all three contexts are free, `budget_left` is 10, `rsp_valid` is low and all sticky flags are clear.
- R2: Context indices are encoded A=0, B=1, C=2. When more than one context is free, the grant picks A first, then C, and B only when A and C are both held.
- R3: A request that finds no free context gets `rsp_err`=1 (busy) with `rsp_grant` low, and leaves the held contexts and the budget unchanged.
- R4: A request whose count is 0, above 10, or above the channels left gets `rsp_err`=2 (count) with `rsp_grant` low, and leaves the held contexts and the budget unchanged. Busy takes precedence over count.
- R5: Every request gets exactly one response, one cycle later. A grant carries `rsp_err`=0, marks the context held, and takes the requested count out of `budget_left`.
- R6: A release of a held context frees it, returns its recorded count to `budget_left` and clears its sticky flag, all visible in the cycle after the release.
- R7: `dis_strobe` is one-hot on bit `rel_ctx` in the same cycle as a release of a held context, while that context still shows as held. The context is free in the next cycle unless it is granted again in that same cycle.
- R8: A release and a request in the same cycle are handled release-first, so the freed context and channels can serve the request.
- R9: A release of a free context, or with `rel_ctx`=3, raises no strobe and changes neither the budget nor the held set.
- R10: `fault_in[i]` sets the sticky flag of context i one cycle later only while context i is held. A grant to a context starts it with its flag clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| req_valid | input | 1 | Request pulse |
| req_cnt | input | 4 | Channels asked for |
| rel_valid | input | 1 | Release pulse |
| rel_ctx | input | 2 | Context to release (A=0, B=1, C=2) |
| fault_in | input | 3 | Per-context fault report |
| rsp_valid | output | 1 | Response present, one cycle after a request |
| rsp_grant | output | 1 | Request granted |
| rsp_ctx | output | 2 | Granted context (0 when refused) |
| rsp_err | output | 2 | 0 none, 1 busy, 2 count |
| dis_strobe | output | 3 | Disable strobe per context, same cycle as release |
| ctx_busy | output | 3 | Held flag per context |
| ctx_flag | output | 3 | Sticky fault flag per context |
| budget_left | output | 4 | Channels still available |

## Verification
The response to a request, and every state change from a grant, release or fault, shows up at the first rising edge after the inputs are driven. The disable strobe is combinational and belongs to the release cycle itself. The bench drives inputs at the falling edge. It reads the strobe shortly after driving, before the edge that acts on it. It reads the response, held set, flags and budget just after the following rising edge, and compares them with a model that it updates only after those reads.

// File: rtl/ctx_alloc_pkg.sv
// Shared types and constants for the channel-budgeted context allocator.
// Assumes exactly three contexts; the grant preference order is fixed here.
package ctx_alloc_pkg;

    localparam int NUM_CTX = 3;

    typedef logic [1:0] ctx_idx_t;

    localparam ctx_idx_t CTX_A = 2'd0;
    localparam ctx_idx_t CTX_B = 2'd1;
    localparam ctx_idx_t CTX_C = 2'd2;

    // Preference order for grants: first entry wins when free.
    localparam ctx_idx_t GRANT_ORDER [NUM_CTX] = '{CTX_A, CTX_C, CTX_B};

    typedef enum logic [1:0] {
        ERR_NONE  = 2'd0,
        ERR_BUSY  = 2'd1,
        ERR_COUNT = 2'd2
    } rsp_err_t;

endpackage

// File: rtl/ctx_pick.sv
// Picks one free context according to the package preference order.
// Assumes free_vec is the effective free set (releases already folded in).
module ctx_pick
    import ctx_alloc_pkg::*;
#(
    parameter int N = NUM_CTX
) (
    input  logic [N-1:0] free_vec,
    output logic         found,
    output ctx_idx_t     pick
);

    // Scan from lowest preference to highest so the last hit wins.
    always_comb begin
        found = 1'b0;
        pick  = CTX_A;
        for (int k = N - 1; k >= 0; k--) begin
            if (free_vec[GRANT_ORDER[k]]) begin
                found = 1'b1;
                pick  = GRANT_ORDER[k];
            end
        end
    end

endmodule

// File: rtl/ctx_tracker.sv
// Holds the per-context held flags and sticky fault flags, decodes
// releases into a strobe, and presents the effective free set.
// Assumes grant_hit is at most one-hot and only targets free_eff contexts.
module ctx_tracker
    import ctx_alloc_pkg::*;
#(
    parameter int N = NUM_CTX
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         rel_valid,
    input  ctx_idx_t     rel_ctx,
    input  logic [N-1:0] grant_hit,
    input  logic [N-1:0] fault_in,
    output logic [N-1:0] rel_hit,
    output logic [N-1:0] free_eff,
    output logic [N-1:0] busy_q,
    output logic [N-1:0] flag_q
);

    genvar gi;
    generate
        for (gi = 0; gi < N; gi++) begin : g_ctx
            // Release decode: only a held context is affected.
            always_comb begin
                rel_hit[gi]  = rel_valid && (rel_ctx == ctx_idx_t'(gi)) && busy_q[gi];
                free_eff[gi] = !busy_q[gi] || rel_hit[gi];
            end

            // Held flag: release clears, grant sets, release first.
            always_ff @(posedge clk) begin
                if (!rst_n)
                    busy_q[gi] <= 1'b0;
                else if (grant_hit[gi])
                    busy_q[gi] <= 1'b1;
                else if (rel_hit[gi])
                    busy_q[gi] <= 1'b0;
            end

            // Sticky fault flag: wiped on release or fresh grant, set while held.
            always_ff @(posedge clk) begin
                if (!rst_n)
                    flag_q[gi] <= 1'b0;
                else if (rel_hit[gi] || grant_hit[gi])
                    flag_q[gi] <= 1'b0;
                else if (fault_in[gi] && busy_q[gi])
                    flag_q[gi] <= 1'b1;
            end
        end
    endgenerate

endmodule

// File: rtl/chan_ledger.sv
// Keeps the shared channel budget and the count recorded per context.
// Assumes rel_hit and grant_hit are each at most one-hot and a grant never
// exceeds avail; avail already includes channels returned this cycle.
module chan_ledger
    import ctx_alloc_pkg::*;
#(
    parameter int N      = NUM_CTX,
    parameter int BUDGET = 10,
    parameter int CNT_W  = $clog2(BUDGET + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N-1:0]     rel_hit,
    input  logic [N-1:0]     grant_hit,
    input  logic [CNT_W-1:0] grant_cnt,
    output logic [CNT_W-1:0] avail,
    output logic [CNT_W-1:0] budget_q,
    output logic [CNT_W-1:0] cnt_q [N]
);

    logic [CNT_W-1:0] returned;
    logic             any_grant;

    // Channels coming back this cycle from the released context.
    always_comb begin
        returned  = '0;
        any_grant = |grant_hit;
        for (int i = 0; i < N; i++) begin
            if (rel_hit[i])
                returned = returned | cnt_q[i];
        end
        avail = budget_q + returned;
    end

    // Pool register: return first, then deduct a grant.
    always_ff @(posedge clk) begin
        if (!rst_n)
            budget_q <= CNT_W'(BUDGET);
        else
            budget_q <= any_grant ? (avail - grant_cnt) : avail;
    end

    genvar gi;
    generate
        for (gi = 0; gi < N; gi++) begin : g_cnt
            // Per-context recorded count.
            always_ff @(posedge clk) begin
                if (!rst_n)
                    cnt_q[gi] <= '0;
                else if (grant_hit[gi])
                    cnt_q[gi] <= grant_cnt;
                else if (rel_hit[gi])
                    cnt_q[gi] <= '0;
            end
        end
    endgenerate

endmodule

// File: rtl/chan_ctx_allocator.sv
// Top of the context allocator: validates requests, chooses a context,
// updates the shared budget and registers a one-cycle-late response.
// Assumes at most one request and one release per cycle.
module chan_ctx_allocator
    import ctx_alloc_pkg::*;
#(
    parameter int CH_BUDGET = 10,
    parameter int REQ_W     = 4,
    localparam int CNT_W    = $clog2(CH_BUDGET + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    input  logic [REQ_W-1:0] req_cnt,
    input  logic             rel_valid,
    input  logic [1:0]       rel_ctx,
    input  logic [2:0]       fault_in,
    output logic             rsp_valid,
    output logic             rsp_grant,
    output logic [1:0]       rsp_ctx,
    output logic [1:0]       rsp_err,
    output logic [2:0]       dis_strobe,
    output logic [2:0]       ctx_busy,
    output logic [2:0]       ctx_flag,
    output logic [CNT_W-1:0] budget_left
);

    logic [NUM_CTX-1:0] rel_hit;
    logic [NUM_CTX-1:0] free_eff;
    logic [NUM_CTX-1:0] grant_hit;
    logic               found;
    ctx_idx_t           pick;
    logic [CNT_W-1:0]   avail;
    logic [CNT_W-1:0]   ctx_cnt [NUM_CTX];
    logic               cnt_ok;
    logic               grant;
    rsp_err_t           err_now;

    ctx_tracker #(.N(NUM_CTX)) i_tracker (
        .clk       (clk),
        .rst_n     (rst_n),
        .rel_valid (rel_valid),
        .rel_ctx   (rel_ctx),
        .grant_hit (grant_hit),
        .fault_in  (fault_in),
        .rel_hit   (rel_hit),
        .free_eff  (free_eff),
        .busy_q    (ctx_busy),
        .flag_q    (ctx_flag)
    );

    ctx_pick #(.N(NUM_CTX)) i_pick (
        .free_vec (free_eff),
        .found    (found),
        .pick     (pick)
    );

    chan_ledger #(.N(NUM_CTX), .BUDGET(CH_BUDGET), .CNT_W(CNT_W)) i_ledger (
        .clk       (clk),
        .rst_n     (rst_n),
        .rel_hit   (rel_hit),
        .grant_hit (grant_hit),
        .grant_cnt (CNT_W'(req_cnt)),
        .avail     (avail),
        .budget_q  (budget_left),
        .cnt_q     (ctx_cnt)
    );

    // Request decision: busy beats count, count checked against the pool.
    always_comb begin
        cnt_ok = (int'(req_cnt) != 0) && (int'(req_cnt) <= CH_BUDGET)
                 && (int'(req_cnt) <= int'(avail));
        grant  = req_valid && found && cnt_ok;
        if (!found)
            err_now = ERR_BUSY;
        else if (!cnt_ok)
            err_now = ERR_COUNT;
        else
            err_now = ERR_NONE;
        grant_hit = '0;
        if (grant)
            grant_hit[pick] = 1'b1;
        dis_strobe = rel_hit;
    end

    // Response register: one response per request, one cycle late.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid <= 1'b0;
            rsp_grant <= 1'b0;
            rsp_ctx   <= CTX_A;
            rsp_err   <= ERR_NONE;
        end else begin
            rsp_valid <= req_valid;
            rsp_grant <= grant;
            rsp_ctx   <= grant ? pick : CTX_A;
            rsp_err   <= req_valid ? err_now : ERR_NONE;
        end
    end

endmodule

// File: rtl/ctx_alloc_chk.sv
// Property checker for chan_ctx_allocator, attached by bind below.
// Assumes the bound instance uses a budget of CH_BUDGET channels.
module ctx_alloc_chk #(
    parameter int CH_BUDGET = 10,
    parameter int CNT_W     = $clog2(CH_BUDGET + 1)
) (
    input logic             clk,
    input logic             rst_n,
    input logic             req_valid,
    input logic             rel_valid,
    input logic             rsp_valid,
    input logic             rsp_grant,
    input logic [1:0]       rsp_ctx,
    input logic [1:0]       rsp_err,
    input logic [2:0]       dis_strobe,
    input logic [2:0]       ctx_busy,
    input logic [CNT_W-1:0] budget_left,
    input logic [CNT_W-1:0] ctx_cnt [3]
);

    // Pool plus recorded counts always add up to the full budget (R5, R6).
    assert_budget_conserved_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (int'(budget_left) + int'(ctx_cnt[0]) + int'(ctx_cnt[1]) + int'(ctx_cnt[2]))
            == CH_BUDGET);

    // A response appears exactly one cycle after each request (R5).
    assert_rsp_follows_req_R5: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid |=> rsp_valid);

    // A grant leaves the chosen context held and carries no error (R5).
    assert_grant_holds_ctx_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_grant) |-> (ctx_busy[rsp_ctx] && rsp_err == 2'd0));

    // Busy refusal without a release changes nothing (R3).
    assert_busy_no_change_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_err == 2'd1 && !$past(rel_valid))
            |-> ($stable(budget_left) && $stable(ctx_busy)));

    // Count refusal without a release changes nothing (R4).
    assert_count_no_change_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_err == 2'd2 && !$past(rel_valid))
            |-> ($stable(budget_left) && $stable(ctx_busy)));

    // At most one strobe at a time (R7).
    assert_strobe_onehot_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(dis_strobe));

    // A strobed context is free next cycle when no request can re-take it (R7).
    assert_strobe_then_free_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ((|dis_strobe) && !req_valid) |=> ((ctx_busy & $past(dis_strobe)) == 3'b000));

endmodule

bind chan_ctx_allocator ctx_alloc_chk #(.CH_BUDGET(CH_BUDGET)) i_ctx_alloc_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .req_valid   (req_valid),
    .rel_valid   (rel_valid),
    .rsp_valid   (rsp_valid),
    .rsp_grant   (rsp_grant),
    .rsp_ctx     (rsp_ctx),
    .rsp_err     (rsp_err),
    .dis_strobe  (dis_strobe),
    .ctx_busy    (ctx_busy),
    .budget_left (budget_left),
    .ctx_cnt     (ctx_cnt)
);

// File: tb/test_chan_ctx_allocator.sv
// Self-checking bench: directed corner cases then seeded random traffic,
// compared against a behavioural model of the requirements.
module test_chan_ctx_allocator;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       req_valid = 1'b0;
    logic [3:0] req_cnt = '0;
    logic       rel_valid = 1'b0;
    logic [1:0] rel_ctx = '0;
    logic [2:0] fault_in = '0;
    logic       rsp_valid, rsp_grant;
    logic [1:0] rsp_ctx, rsp_err;
    logic [2:0] dis_strobe, ctx_busy, ctx_flag;
    logic [3:0] budget_left;

    int n_chk = 0;
    int n_bad = 0;

    // Model state
    bit m_busy [3];
    bit m_flag [3];
    int m_cnt  [3];
    int m_budget;

    always #2 clk = ~clk;

    chan_ctx_allocator i_chan_ctx_allocator (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_cnt(req_cnt),
        .rel_valid(rel_valid), .rel_ctx(rel_ctx), .fault_in(fault_in),
        .rsp_valid(rsp_valid), .rsp_grant(rsp_grant), .rsp_ctx(rsp_ctx),
        .rsp_err(rsp_err), .dis_strobe(dis_strobe), .ctx_busy(ctx_busy),
        .ctx_flag(ctx_flag), .budget_left(budget_left)
    );

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    function automatic int pack3(input bit b [3]);
        return int'(b[0]) | (int'(b[1]) << 1) | (int'(b[2]) << 2);
    endfunction

    // One cycle of stimulus with full checking against the model.
    task automatic step(input bit rv, input int rc, input bit lv, input int lc,
                        input int flt);
        bit    rel_h [3];
        int    avail, pick, exp_err, exp_ctx;
        bit    found, g;
        bit    nb [3];
        @(negedge clk);
        req_valid = rv; req_cnt = 4'(rc);
        rel_valid = lv; rel_ctx = 2'(lc); fault_in = 3'(flt);
        #1;
        for (int i = 0; i < 3; i++) rel_h[i] = lv && (lc == i) && m_busy[i];
        chk("R7 strobe", int'(dis_strobe), pack3(rel_h));
        avail = m_budget;
        for (int i = 0; i < 3; i++) begin
            if (rel_h[i]) avail += m_cnt[i];
            nb[i] = m_busy[i] && !rel_h[i];
        end
        found = 1'b1;
        if (!nb[0]) pick = 0;
        else if (!nb[2]) pick = 2;
        else if (!nb[1]) pick = 1;
        else found = 1'b0;
        if (!found) exp_err = 1;
        else if (rc == 0 || rc > 10 || rc > avail) exp_err = 2;
        else exp_err = 0;
        g = rv && (exp_err == 0);
        exp_ctx = g ? pick : 0;
        @(posedge clk);
        #1;
        // model update
        for (int i = 0; i < 3; i++) begin
            bit gi;
            gi = g && (pick == i);
            if (rel_h[i] || gi) m_flag[i] = 1'b0;
            else if (flt[i] && m_busy[i]) m_flag[i] = 1'b1;
            if (gi) begin m_busy[i] = 1'b1; m_cnt[i] = rc; end
            else if (rel_h[i]) begin m_busy[i] = 1'b0; m_cnt[i] = 0; end
        end
        m_budget = g ? avail - rc : avail;
        chk("R5 rsp_valid", int'(rsp_valid), int'(rv));
        if (rv) begin
            chk(exp_err == 1 ? "R3 err" : (exp_err == 2 ? "R4 err" : "R5 err"),
                int'(rsp_err), exp_err);
            chk("R5 grant", int'(rsp_grant), int'(g));
            chk("R2 ctx", int'(rsp_ctx), exp_ctx);
        end
        chk("R6 busy", int'(ctx_busy), pack3(m_busy));
        chk("R6 budget", int'(budget_left), m_budget);
        chk("R10 flags", int'(ctx_flag), pack3(m_flag));
        req_valid = 1'b0; rel_valid = 1'b0; fault_in = '0;
    endtask

    initial begin
        #(4 * 200000);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual hung expected done");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        for (int i = 0; i < 3; i++) begin m_busy[i] = 0; m_flag[i] = 0; m_cnt[i] = 0; end
        m_budget = 10;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        // R1: reset state
        chk("R1 busy", int'(ctx_busy), 0);
        chk("R1 budget", int'(budget_left), 10);
        chk("R1 rsp_valid", int'(rsp_valid), 0);
        chk("R1 flags", int'(ctx_flag), 0);

        // R2: preference A, C, B
        step(1, 2, 0, 0, 0); chk("R2 first A", int'(rsp_ctx), 0);
        step(1, 2, 0, 0, 0); chk("R2 second C", int'(rsp_ctx), 2);
        step(1, 3, 0, 0, 0); chk("R2 third B", int'(rsp_ctx), 1);
        // R3: all held
        step(1, 1, 0, 0, 0); chk("R3 busy code", int'(rsp_err), 1);
        // R10: fault on held context
        step(0, 0, 0, 0, 3'b010);
        // R8: release B and request in same cycle, B re-granted with 5 channels
        step(1, 5, 1, 1, 0);
        chk("R8 regrant B", int'(rsp_ctx), 1);
        chk("R8 grant", int'(rsp_grant), 1);
        // R6: release A
        step(0, 0, 1, 0, 0);
        // R9: release A again, nothing changes
        step(0, 0, 1, 0, 0);
        chk("R9 budget", int'(budget_left), 3);
        step(0, 0, 1, 3, 0);
        chk("R9 busy", int'(ctx_busy), 3'b110);
        // R4: zero, oversize, above remaining
        step(1, 0, 0, 0, 0);
        step(1, 11, 0, 0, 0);
        step(1, 4, 0, 0, 0); chk("R4 above remaining", int'(rsp_err), 2);
        step(1, 3, 0, 0, 0); chk("R4 exact fit granted", int'(rsp_grant), 1);

        // Seeded random traffic
        for (int n = 0; n < 3000; n++) begin
            step($urandom_range(0, 1) == 1, int'($urandom_range(0, 12)),
                 $urandom_range(0, 9) < 4, int'($urandom_range(0, 3)),
                 ($urandom_range(0, 9) == 0) ? int'($urandom_range(0, 7)) : 0);
        end

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule